// File: doc/BRIEF.md
# Masked Interrupt Cause Aggregator

This block collects up to 64 level-sensitive interrupt sources into a 64-bit cause register. It ANDs the cause with a 64-bit CPU enable mask and drives a single interrupt line to the processor. Software reaches the block through a simple word-wide register port. The port returns the two halves of the cause, the two halves of the mask, and a summary word. The summary word shows which half holds enabled pending interrupts, so a handler needs only one read to find where to look.

One cause position is taken by a small general-purpose-pin interrupt unit. That unit has its own pin cause register and its own enable mask. Its mask can be reached at two addresses. It also holds a pin value register that can be written directly, or changed bit by bit through set and clear addresses.

Top module: `irq_cause_agg`

## Requirements
- R1: Every cause bit n other than bit 63 equals the level that source input n had at the previous rising clock edge. The bit is set while the input is high and clears once the input is low.
- R2: `irq_o` is high exactly when at least one cause bit is set together with the same mask bit. It changes in the cycle in which the cause register or the mask register takes its new value.
- R3: After reset the cause, mask, pin value, pin mask and read data are all zero, and `irq_o` is low.
- R4: A read takes effect at a rising edge and its result is on `rdata_o` from that edge onward. It returns the state from before that edge. Address 0 returns cause bits 31:0 and address 1 returns cause bits 63:32. Address 2 reads and writes mask bits 31:0, and address 3 reads and writes mask bits 63:32.
- R5: A read of address 4 returns cause bits 31:0 unchanged when the enabled cause (cause AND mask) has no bit set in its upper half.
- R6: A read of address 4 returns cause bits 63:32 with bit 30 forced to 1 when enabled pending bits exist only in the upper half.
- R7: A read of address 4 returns cause bits 31:0 with bit 31 forced to 1 when enabled pending bits exist in both halves.
- R8: Address 5 reads and writes the pin value, which is also driven on `gpp_val_o`. A write to address 6 ORs the written bits into the value, and a write to address 7 clears the written bits. Addresses 6 and 7 always read as zero.
- R9: Addresses 9 and 10 both write and read back the same single pin interrupt mask.
- R10: The pin cause (address 8, read only) holds the levels of `gpp_pin_i` from the previous edge. Cause bit 63 holds the OR of (pin cause AND pin mask) from the previous edge, so it trails a pin change by two edges. Source input 63 is ignored.
- R11: Addresses 11 to 15 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level interrupt sources; bit 63 unused |
| gpp_pin_i | input | 32 | General-purpose pin interrupt levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| gpp_val_o | output | 32 | General-purpose pin value register |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
A source change reaches the cause register at the next edge. A pin change needs two edges to reach cause bit 63. `irq_o` follows at the same edge as the cause or mask update, and read data appears one edge after the strobe. The bench drives every input on the falling edge. It samples one falling edge after a write or source change, and two after a pin change. A scoreboard queue holds the expected read results, and a monitor pops one entry on each falling edge that follows a captured read strobe.

// File: rtl/irq_cause_agg.sv
module irq_cause_agg #(
  parameter int W       = 32,
  parameter int GPW     = 32,
  parameter int GPP_IDX = 2*W-1,
  parameter int AW      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*W-1:0] src_i,
  input  logic [GPW-1:0] gpp_pin_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  output logic [GPW-1:0] gpp_val_o,
  output logic           irq_o
);
  localparam int NS = 2*W;
  localparam logic [AW-1:0] A_CLO  = AW'(0);
  localparam logic [AW-1:0] A_CHI  = AW'(1);
  localparam logic [AW-1:0] A_MLO  = AW'(2);
  localparam logic [AW-1:0] A_MHI  = AW'(3);
  localparam logic [AW-1:0] A_SEL  = AW'(4);
  localparam logic [AW-1:0] A_GVAL = AW'(5);
  localparam logic [AW-1:0] A_GSET = AW'(6);
  localparam logic [AW-1:0] A_GCLR = AW'(7);
  localparam logic [AW-1:0] A_GCAU = AW'(8);
  localparam logic [AW-1:0] A_GMKA = AW'(9);
  localparam logic [AW-1:0] A_GMKB = AW'(10);

  logic [NS-1:0]  cause_q, mask_q, cause_d, pend;
  logic [GPW-1:0] gcause_q, gmask_q, gval_q;
  logic [W-1:0]   rdata_q, rd_mux, sel_word;
  logic           gpp_src, pend_lo, pend_hi;

  assign pend    = cause_q & mask_q;
  assign pend_lo = |pend[W-1:0];
  assign pend_hi = |pend[NS-1:W];
  assign irq_o   = pend_lo | pend_hi;
  assign gpp_src = |(gcause_q & gmask_q);

  always_comb begin
    cause_d          = src_i;
    cause_d[GPP_IDX] = gpp_src;
  end

  always_comb begin
    sel_word = cause_q[W-1:0];
    if (pend_hi && !pend_lo) begin
      sel_word      = cause_q[NS-1:W];
      sel_word[W-2] = 1'b1;
    end else if (pend_hi && pend_lo) begin
      sel_word[W-1] = 1'b1;
    end
  end

  always_comb begin
    case (addr_i)
      A_CLO:          rd_mux = cause_q[W-1:0];
      A_CHI:          rd_mux = cause_q[NS-1:W];
      A_MLO:          rd_mux = mask_q[W-1:0];
      A_MHI:          rd_mux = mask_q[NS-1:W];
      A_SEL:          rd_mux = sel_word;
      A_GVAL:         rd_mux = W'(gval_q);
      A_GCAU:         rd_mux = W'(gcause_q);
      A_GMKA, A_GMKB: rd_mux = W'(gmask_q);
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q  <= '0;
      gcause_q <= '0;
    end else begin
      cause_q  <= cause_d;
      gcause_q <= gpp_pin_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      gmask_q <= '0;
      gval_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MLO:          mask_q[W-1:0]  <= wdata_i;
        A_MHI:          mask_q[NS-1:W] <= wdata_i;
        A_GVAL:         gval_q         <= wdata_i[GPW-1:0];
        A_GSET:         gval_q         <= gval_q | wdata_i[GPW-1:0];
        A_GCLR:         gval_q         <= gval_q & ~wdata_i[GPW-1:0];
        A_GMKA, A_GMKB: gmask_q        <= wdata_i[GPW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign gpp_val_o = gval_q;
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk #(
  parameter int W       = 32,
  parameter int GPP_IDX = 2*W-1,
  parameter int AW      = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*W-1:0] src_i,
  input logic           rd_en_i,
  input logic [AW-1:0]  addr_i,
  input logic [W-1:0]   rdata_o,
  input logic           irq_o,
  input logic [2*W-1:0] cause_q,
  input logic [2*W-1:0] mask_q
);
  localparam logic [2*W-1:0] KEEP = ~((2*W)'(1) << GPP_IDX);

  a_r1_src_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((cause_q & KEEP) == ($past(src_i) & KEEP)));

  a_r2_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  a_r6_upper_only_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == AW'(4) && ((cause_q & mask_q) != '0)
     && ((cause_q[W-1:0] & mask_q[W-1:0]) == '0)) |=> rdata_o[W-2]);

  a_r8_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (addr_i == AW'(6) || addr_i == AW'(7))) |=> (rdata_o == '0));

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i >= AW'(11)) |=> (rdata_o == '0));
endmodule

bind irq_cause_agg irq_cause_agg_chk #(.W(W), .GPP_IDX(GPP_IDX), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .cause_q(cause_q), .mask_q(mask_q));

// File: tb/irq_cause_agg_tb.sv
module irq_cause_agg_tb;
  logic        clk = 0, rst_n = 0;
  logic [63:0] src = '0;
  logic [31:0] pins = '0, wdata = '0;
  logic        wr_en = 0, rd_en = 0, pending = 0;
  logic [3:0]  addr = '0;
  logic [31:0] rdata, gval;
  logic        irq;
  int          n_chk = 0, n_err = 0;

  typedef struct { string tag; logic [31:0] exp; } item_t;
  item_t sb[$];

  irq_cause_agg u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .gpp_pin_i(pins),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .gpp_val_o(gval), .irq_o(irq));

  always #4 clk = ~clk;

  always @(posedge clk) pending <= rd_en;

  always @(negedge clk) begin
    if (pending && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_err++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, string tag, logic [31:0] exp);
    item_t it;
    it.tag = tag; it.exp = exp;
    rd_en = 1; addr = a;
    sb.push_back(it);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: got=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    check("R3 irq after reset", {31'b0, irq}, 0);
    check("R3 pin value after reset", gval, 0);
    rd(2, "R3 mask lo reset", 0);
    rd(3, "R3 mask hi reset", 0);
    rd(0, "R3 cause lo reset", 0);

    src = 64'h0000_0001_0000_0010;
    tick(1);
    rd(0, "R1 R4 cause lo", 32'h10);
    rd(1, "R1 R4 cause hi", 32'h1);
    check("R2 masked off", {31'b0, irq}, 0);
    rd(4, "R5 nothing enabled", 32'h10);

    wr(3, 32'h1);
    check("R2 irq on mask hi", {31'b0, irq}, 1);
    rd(3, "R4 mask hi", 32'h1);
    rd(4, "R6 upper only", 32'h4000_0001);
    wr(2, 32'h10);
    rd(4, "R7 both halves", 32'h8000_0010);
    wr(3, 32'h0);
    rd(4, "R5 lower only", 32'h10);
    check("R2 irq lower", {31'b0, irq}, 1);

    src = 64'h0000_0001_0000_0000;
    tick(1);
    check("R1 R2 source drop", {31'b0, irq}, 0);
    rd(0, "R1 cause lo cleared", 0);

    wr(5, 32'hF0);
    wr(6, 32'h3);
    wr(7, 32'h30);
    check("R8 pin value port", gval, 32'hC3);
    rd(5, "R8 pin value", 32'hC3);
    rd(6, "R8 set reads zero", 0);
    rd(7, "R8 clear reads zero", 0);

    wr(9, 32'h5);
    rd(10, "R9 alias b", 32'h5);
    wr(10, 32'h4);
    rd(9, "R9 alias a", 32'h4);

    wr(2, 32'h0);
    wr(3, 32'h8000_0000);
    src[63] = 1'b1;
    tick(2);
    check("R10 src63 ignored", {31'b0, irq}, 0);
    pins = 32'h4;
    tick(1);
    check("R10 one edge not yet", {31'b0, irq}, 0);
    tick(1);
    check("R10 pin irq", {31'b0, irq}, 1);
    rd(8, "R10 pin cause", 32'h4);
    rd(1, "R10 cause hi", 32'h8000_0001);
    pins = 32'h1;
    tick(2);
    check("R10 pin masked", {31'b0, irq}, 0);

    wr(12, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    rd(12, "R11 unmapped read", 0);
    rd(3, "R11 mask hi intact", 32'h8000_0000);
    rd(2, "R11 mask lo intact", 0);
    rd(5, "R11 pin value intact", 32'hC3);
    rd(9, "R11 pin mask intact", 32'h4);
    tick(2);
    if (sb.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R4 scoreboard: got=%0d expected=0 left", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule